// File: doc/BRIEF.md
# Mode-Banked General Register File

This block holds the sixteen 32-bit general registers of a processor core together with eleven control registers. The low eight general registers are built twice, as bank 0 and bank 1. The copy that ordinary instructions reach is picked from two inputs, the privilege mode and a bank-select bit. Only a privileged core with the bank bit at 1 sees bank 1. Every other combination sees bank 0. Registers 8 to 15 form one shared set that every mode sees.

Ordinary instructions use two combinational read ports and one clocked write port. A side port, indexed by three bits, always reaches the copy of registers 0 to 7 that is currently hidden. It serves the instructions that move data between banks.

The control registers are reached through a select code. Five of them are privileged only. Any access from user mode to one of those five, or to the side port, is blocked: its read data is zero, its write is dropped, and a fault flag rises for one cycle.

Top module: `banked_regfile`

## Requirements
- R1: A synchronous reset, active high, clears both banks, the shared registers and all control registers to zero, and clears the fault flag.
- R2: Indices 8 to 15 on the normal ports address one shared set of registers, whatever the mode and bank bit.
- R3: In user mode (priv_mode=0), indices 0 to 7 on the normal ports address bank 0, whatever bank_sel holds.
- R4: In privileged mode, indices 0 to 7 address bank 1 when bank_sel=1 and bank 0 when bank_sel=0. A change of mode or bank bit shows on the read data in the same cycle.
- R5: In privileged mode the side port (3-bit index) reads and writes the bank that is not active. Its writes leave the active bank unchanged.
- R6: The read ports are combinational and writes take effect at the rising edge. A read of the register being written in that cycle returns the old value.
- R7: Control select codes 0 to 5 are open in every mode and codes 6 to 10 are privileged only. Codes 11 to 15 read as zero and ignore writes.
- R8: In user mode, an access to a privileged-only control code or to the side port writes nothing, and its read data is zero.
- R9: priv_fault is high in exactly the cycle after a cycle that held a blocked access (R8), and low otherwise.
- R10: The two read ports return the contents of two different registers in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| priv_mode | input | 1 | 1 = privileged, 0 = user |
| bank_sel | input | 1 | Bank bit, applies only in privileged mode |
| rd_a_idx | input | 4 | Read port A register index |
| rd_a_data | output | 32 | Read port A data |
| rd_b_idx | input | 4 | Read port B register index |
| rd_b_data | output | 32 | Read port B data |
| wr_en | input | 1 | Normal write enable |
| wr_idx | input | 4 | Normal write index |
| wr_data | input | 32 | Normal write data |
| alt_en | input | 1 | Side port access strobe |
| alt_we | input | 1 | Side port write |
| alt_idx | input | 3 | Side port index into the hidden bank |
| alt_wdata | input | 32 | Side port write data |
| alt_rdata | output | 32 | Side port read data |
| ctl_en | input | 1 | Control port access strobe |
| ctl_we | input | 1 | Control port write |
| ctl_sel | input | 4 | Control register select code |
| ctl_wdata | input | 32 | Control write data |
| ctl_rdata | output | 32 | Control read data |
| priv_fault | output | 1 | One-cycle privilege violation flag |

## Verification
The bench stores different values in the same low index of each bank. It then reads that index under every mode and bank-bit setting, so a design that ignores privilege when it picks the bank returns the wrong copy. Side-port writes are followed by reads of the active bank, which catches a design that writes the side data into the visible copy. It also sends blocked user-mode writes to the side port and to a privileged control code, then reads both back as privileged: a leaky privilege gate shows up as corrupted values, a missing fault pulse, or one that stays high too long. A same-cycle read and write exposes an unwanted bypass, and a reset after every store has been filled catches any register that reset does not clear.

// File: rtl/bankreg_pkg.sv
package bankreg_pkg;

  localparam int CTRL_SEL_W = 4;
  localparam int NUM_CTRL   = 11;
  localparam int FIRST_PRIV = 6;

  typedef enum logic [CTRL_SEL_W-1:0] {
    CR_GLOBAL_BASE = 4'd0,
    CR_MAC_HI      = 4'd1,
    CR_MAC_LO      = 4'd2,
    CR_RET_ADDR    = 4'd3,
    CR_STATUS      = 4'd4,
    CR_PROG_CNT    = 4'd5,
    CR_SAVED_STAT  = 4'd6,
    CR_SAVED_PC    = 4'd7,
    CR_VEC_BASE    = 4'd8,
    CR_SAVED_GEN   = 4'd9,
    CR_DEBUG_BASE  = 4'd10
  } ctrl_sel_e;

  // Active bank: only privileged mode with the bank bit set reaches bank 1
  function automatic logic pick_bank(input logic priv, input logic bank_bit);
    return priv & bank_bit;
  endfunction

  function automatic logic ctrl_valid(input logic [CTRL_SEL_W-1:0] sel);
    return sel < CTRL_SEL_W'(NUM_CTRL);
  endfunction

  function automatic logic ctrl_priv_only(input logic [CTRL_SEL_W-1:0] sel);
    return (sel >= CTRL_SEL_W'(FIRST_PRIV)) && (sel < CTRL_SEL_W'(NUM_CTRL));
  endfunction

endpackage

// File: rtl/bank_select.sv
module bank_select (
  input  logic priv_mode,
  input  logic bank_sel,
  output logic act_bank,
  output logic hid_bank,
  output logic side_ok
);
  import bankreg_pkg::*;

  always_comb begin
    act_bank = pick_bank(priv_mode, bank_sel);
    hid_bank = ~act_bank;
    side_ok  = priv_mode;
  end
endmodule

// File: rtl/gpr_array.sv
module gpr_array #(
  parameter int DATA_W     = 32,
  parameter int NUM_REGS   = 16,
  parameter int NUM_BANKED = 8
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          act_bank,
  input  logic                          hid_bank,
  input  logic [$clog2(NUM_REGS)-1:0]   rd_a_idx,
  input  logic [$clog2(NUM_REGS)-1:0]   rd_b_idx,
  output logic [DATA_W-1:0]             rd_a_data,
  output logic [DATA_W-1:0]             rd_b_data,
  input  logic                          wr_en,
  input  logic [$clog2(NUM_REGS)-1:0]   wr_idx,
  input  logic [DATA_W-1:0]             wr_data,
  input  logic                          side_we,
  input  logic [$clog2(NUM_BANKED)-1:0] side_idx,
  input  logic [DATA_W-1:0]             side_wdata,
  output logic [DATA_W-1:0]             side_rdata
);
  localparam int IDX_W      = $clog2(NUM_REGS);
  localparam int BIDX_W     = $clog2(NUM_BANKED);
  localparam int NUM_SHARED = NUM_REGS - NUM_BANKED;
  localparam int SIDX_W     = (NUM_SHARED > 1) ? $clog2(NUM_SHARED) : 1;

  logic [DATA_W-1:0] bank_q   [2][NUM_BANKED];
  logic [DATA_W-1:0] shared_q [NUM_SHARED];

  function automatic logic is_banked(input logic [IDX_W-1:0] idx);
    return idx < IDX_W'(NUM_BANKED);
  endfunction

  function automatic logic [SIDX_W-1:0] shared_slot(input logic [IDX_W-1:0] idx);
    return SIDX_W'(idx - IDX_W'(NUM_BANKED));
  endfunction

  logic              bank_wr, shared_wr;
  logic [BIDX_W-1:0] bank_wslot;
  logic [SIDX_W-1:0] shared_wslot;

  always_comb begin
    bank_wr      = wr_en & is_banked(wr_idx);
    shared_wr    = wr_en & ~is_banked(wr_idx);
    bank_wslot   = wr_idx[BIDX_W-1:0];
    shared_wslot = shared_slot(wr_idx);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int b = 0; b < 2; b++)
        for (int i = 0; i < NUM_BANKED; i++)
          bank_q[b][i] <= '0;
      for (int j = 0; j < NUM_SHARED; j++)
        shared_q[j] <= '0;
    end else begin
      if (bank_wr)   bank_q[act_bank][bank_wslot] <= wr_data;
      if (side_we)   bank_q[hid_bank][side_idx]   <= side_wdata;
      if (shared_wr) shared_q[shared_wslot]       <= wr_data;
    end
  end

  // Two identical combinational read ports
  logic [1:0][IDX_W-1:0]  port_idx;
  logic [1:0][DATA_W-1:0] port_data;

  assign port_idx[0] = rd_a_idx;
  assign port_idx[1] = rd_b_idx;
  assign rd_a_data   = port_data[0];
  assign rd_b_data   = port_data[1];

  for (genvar p = 0; p < 2; p++) begin : g_rd
    always_comb begin
      if (is_banked(port_idx[p]))
        port_data[p] = bank_q[act_bank][port_idx[p][BIDX_W-1:0]];
      else
        port_data[p] = shared_q[shared_slot(port_idx[p])];
    end
  end

  assign side_rdata = bank_q[hid_bank][side_idx];
endmodule

// File: rtl/ctrl_regs.sv
module ctrl_regs #(
  parameter int DATA_W = 32
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                priv_mode,
  input  logic                                ctl_en,
  input  logic                                ctl_we,
  input  logic [bankreg_pkg::CTRL_SEL_W-1:0]  ctl_sel,
  input  logic [DATA_W-1:0]                   ctl_wdata,
  output logic [DATA_W-1:0]                   ctl_rdata,
  output logic                                ctl_blocked,
  output logic                                ctl_wr_fire
);
  import bankreg_pkg::*;

  logic [DATA_W-1:0] ctrl_q [NUM_CTRL];
  logic              denied;

  always_comb begin
    denied      = ~priv_mode & ctrl_priv_only(ctl_sel);
    ctl_blocked = ctl_en & denied;
    ctl_wr_fire = ctl_en & ctl_we & ctrl_valid(ctl_sel) & ~denied;
    if (ctrl_valid(ctl_sel) && !denied)
      ctl_rdata = ctrl_q[ctl_sel];
    else
      ctl_rdata = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < NUM_CTRL; k++)
        ctrl_q[k] <= '0;
    end else if (ctl_wr_fire) begin
      ctrl_q[ctl_sel] <= ctl_wdata;
    end
  end
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile #(
  parameter int DATA_W     = 32,
  parameter int NUM_REGS   = 16,
  parameter int NUM_BANKED = 8
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                priv_mode,
  input  logic                                bank_sel,
  input  logic [$clog2(NUM_REGS)-1:0]         rd_a_idx,
  output logic [DATA_W-1:0]                   rd_a_data,
  input  logic [$clog2(NUM_REGS)-1:0]         rd_b_idx,
  output logic [DATA_W-1:0]                   rd_b_data,
  input  logic                                wr_en,
  input  logic [$clog2(NUM_REGS)-1:0]         wr_idx,
  input  logic [DATA_W-1:0]                   wr_data,
  input  logic                                alt_en,
  input  logic                                alt_we,
  input  logic [$clog2(NUM_BANKED)-1:0]       alt_idx,
  input  logic [DATA_W-1:0]                   alt_wdata,
  output logic [DATA_W-1:0]                   alt_rdata,
  input  logic                                ctl_en,
  input  logic                                ctl_we,
  input  logic [bankreg_pkg::CTRL_SEL_W-1:0]  ctl_sel,
  input  logic [DATA_W-1:0]                   ctl_wdata,
  output logic [DATA_W-1:0]                   ctl_rdata,
  output logic                                priv_fault
);
  // Named internal events, brought out for the checker
  logic              act_bank, hid_bank, side_ok;
  logic              alt_blocked, alt_wr_fire;
  logic              ctl_blocked, ctl_wr_fire;
  logic [DATA_W-1:0] side_raw;
  logic              fault_q;

  bank_select u_bsel (
    .priv_mode (priv_mode),
    .bank_sel  (bank_sel),
    .act_bank  (act_bank),
    .hid_bank  (hid_bank),
    .side_ok   (side_ok)
  );

  assign alt_blocked = alt_en & ~side_ok;
  assign alt_wr_fire = alt_en & alt_we & side_ok;
  assign alt_rdata   = side_ok ? side_raw : '0;

  gpr_array #(
    .DATA_W     (DATA_W),
    .NUM_REGS   (NUM_REGS),
    .NUM_BANKED (NUM_BANKED)
  ) u_gpr (
    .clk        (clk),
    .rst        (rst),
    .act_bank   (act_bank),
    .hid_bank   (hid_bank),
    .rd_a_idx   (rd_a_idx),
    .rd_b_idx   (rd_b_idx),
    .rd_a_data  (rd_a_data),
    .rd_b_data  (rd_b_data),
    .wr_en      (wr_en),
    .wr_idx     (wr_idx),
    .wr_data    (wr_data),
    .side_we    (alt_wr_fire),
    .side_idx   (alt_idx),
    .side_wdata (alt_wdata),
    .side_rdata (side_raw)
  );

  ctrl_regs #(.DATA_W(DATA_W)) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .priv_mode   (priv_mode),
    .ctl_en      (ctl_en),
    .ctl_we      (ctl_we),
    .ctl_sel     (ctl_sel),
    .ctl_wdata   (ctl_wdata),
    .ctl_rdata   (ctl_rdata),
    .ctl_blocked (ctl_blocked),
    .ctl_wr_fire (ctl_wr_fire)
  );

  always_ff @(posedge clk) begin
    if (rst) fault_q <= 1'b0;
    else     fault_q <= alt_blocked | ctl_blocked;
  end

  assign priv_fault = fault_q;
endmodule

// File: rtl/banked_regfile_chk.sv
module banked_regfile_chk #(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              priv_mode,
  input logic              bank_sel,
  input logic [IDX_W-1:0]  rd_a_idx,
  input logic [DATA_W-1:0] rd_a_data,
  input logic              wr_en,
  input logic              alt_en,
  input logic [DATA_W-1:0] alt_rdata,
  input logic [3:0]        ctl_sel,
  input logic [DATA_W-1:0] ctl_rdata,
  input logic              priv_fault,
  input logic              alt_blocked,
  input logic              alt_wr_fire,
  input logic              ctl_blocked
);
  AST_USER_SIDE_ZERO: assert property (@(posedge clk) disable iff (rst)
    (!priv_mode && alt_en) |-> (alt_rdata == '0)); // R8

  AST_USER_CTRL_ZERO: assert property (@(posedge clk) disable iff (rst)
    (!priv_mode && ctl_sel >= 4'd6 && ctl_sel <= 4'd10) |-> (ctl_rdata == '0)); // R8

  AST_BAD_SEL_ZERO: assert property (@(posedge clk) disable iff (rst)
    (ctl_sel > 4'd10) |-> (ctl_rdata == '0)); // R7

  AST_FAULT_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    (alt_blocked || ctl_blocked) |=> priv_fault); // R9

  AST_FAULT_CAUSED: assert property (@(posedge clk) disable iff (rst)
    priv_fault |-> $past(alt_blocked || ctl_blocked)); // R9

  AST_SIDE_KEEPS_ACTIVE: assert property (@(posedge clk) disable iff (rst)
    ($past(alt_wr_fire && !wr_en) && $stable(rd_a_idx) && $stable(priv_mode)
     && $stable(bank_sel)) |-> $stable(rd_a_data)); // R5
endmodule

bind banked_regfile banked_regfile_chk #(.DATA_W(DATA_W), .IDX_W($clog2(NUM_REGS))) u_chk (
  .clk         (clk),
  .rst         (rst),
  .priv_mode   (priv_mode),
  .bank_sel    (bank_sel),
  .rd_a_idx    (rd_a_idx),
  .rd_a_data   (rd_a_data),
  .wr_en       (wr_en),
  .alt_en      (alt_en),
  .alt_rdata   (alt_rdata),
  .ctl_sel     (ctl_sel),
  .ctl_rdata   (ctl_rdata),
  .priv_fault  (priv_fault),
  .alt_blocked (alt_blocked),
  .alt_wr_fire (alt_wr_fire),
  .ctl_blocked (ctl_blocked)
);

// File: tb/sim_banked_regfile.sv
`timescale 1ns/1ps
module sim_banked_regfile;
  logic        clk = 1'b0;
  logic        rst;
  logic        priv_mode, bank_sel;
  logic [3:0]  rd_a_idx, rd_b_idx, wr_idx, ctl_sel;
  logic [31:0] rd_a_data, rd_b_data, wr_data, alt_wdata, alt_rdata, ctl_wdata, ctl_rdata;
  logic        wr_en, alt_en, alt_we, ctl_en, ctl_we, priv_fault;
  logic [2:0]  alt_idx;

  int n_chk = 0;
  int n_err = 0;

  always #10 clk = ~clk;

  banked_regfile u0 (
    .clk(clk), .rst(rst), .priv_mode(priv_mode), .bank_sel(bank_sel),
    .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data), .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .alt_en(alt_en), .alt_we(alt_we), .alt_idx(alt_idx), .alt_wdata(alt_wdata), .alt_rdata(alt_rdata),
    .ctl_en(ctl_en), .ctl_we(ctl_we), .ctl_sel(ctl_sel), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
    .priv_fault(priv_fault)
  );

  typedef struct packed {
    logic        priv;
    logic        bank;
    logic        we;
    logic [3:0]  widx;
    logic [31:0] wdata;
    logic [3:0]  ridx;
    logic [31:0] exp;
  } vec_t;

  // Expected values follow from the bank mapping rules alone
  localparam vec_t VEC [10] = '{
    '{1'b0, 1'b0, 1'b1, 4'd3, 32'h0000_00A1, 4'd3, 32'h0000_00A1},
    '{1'b1, 1'b1, 1'b1, 4'd3, 32'h0000_00B1, 4'd3, 32'h0000_00B1},
    '{1'b1, 1'b0, 1'b0, 4'd0, 32'h0,         4'd3, 32'h0000_00A1},
    '{1'b0, 1'b1, 1'b0, 4'd0, 32'h0,         4'd3, 32'h0000_00A1},
    '{1'b0, 1'b0, 1'b1, 4'd9, 32'h0000_00C9, 4'd9, 32'h0000_00C9},
    '{1'b1, 1'b1, 1'b0, 4'd0, 32'h0,         4'd9, 32'h0000_00C9},
    '{1'b1, 1'b1, 1'b1, 4'd9, 32'h0000_00D9, 4'd9, 32'h0000_00D9},
    '{1'b0, 1'b0, 1'b0, 4'd0, 32'h0,         4'd9, 32'h0000_00D9},
    '{1'b1, 1'b1, 1'b1, 4'd0, 32'h0000_00E0, 4'd0, 32'h0000_00E0},
    '{1'b1, 1'b0, 1'b0, 4'd0, 32'h0,         4'd0, 32'h0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    wr_en = 0; alt_en = 0; alt_we = 0; ctl_en = 0; ctl_we = 0;
  endtask

  task automatic ctl_write(input logic [3:0] sel, input logic [31:0] d);
    ctl_en = 1; ctl_we = 1; ctl_sel = sel; ctl_wdata = d;
    tick();
    idle();
  endtask

  initial begin
    #(20 * 100000);
    n_err++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    rst = 1; priv_mode = 0; bank_sel = 0;
    rd_a_idx = 0; rd_b_idx = 0; wr_idx = 0; wr_data = 0;
    alt_idx = 0; alt_wdata = 0; ctl_sel = 0; ctl_wdata = 0;
    idle();
    tick(); tick();
    rst = 0;

    // R1: reset state
    for (int i = 0; i < 16; i++) begin
      rd_a_idx = 4'(i); #1;
      chk("R1 gpr after reset", rd_a_data, 32'h0);
    end
    chk("R1 fault after reset", {31'h0, priv_fault}, 32'h0);

    // R2 R3 R4: vector table
    for (int v = 0; v < 10; v++) begin
      priv_mode = VEC[v].priv; bank_sel = VEC[v].bank;
      wr_en = VEC[v].we; wr_idx = VEC[v].widx; wr_data = VEC[v].wdata;
      rd_a_idx = VEC[v].ridx;
      tick();
      wr_en = 0; #1;
      chk("R2/R3/R4 vector", rd_a_data, VEC[v].exp);
    end

    // R4: bank change seen in the same cycle
    priv_mode = 1; bank_sel = 1; rd_a_idx = 3; #1;
    chk("R4 bank1 visible", rd_a_data, 32'hB1);
    bank_sel = 0; #1;
    chk("R4 immediate switch", rd_a_data, 32'hA1);

    // R10: two ports at once
    rd_a_idx = 3; rd_b_idx = 9; #1;
    chk("R10 port A", rd_a_data, 32'hA1);
    chk("R10 port B", rd_b_data, 32'hD9);

    // R5: side port reaches hidden bank 1 while bank 0 is active
    alt_en = 1; alt_we = 1; alt_idx = 3; alt_wdata = 32'hF3;
    tick();
    alt_we = 0; #1;
    chk("R5 active untouched", rd_a_data, 32'hA1);
    chk("R5 side read hidden", alt_rdata, 32'hF3);
    chk("R9 no fault privileged", {31'h0, priv_fault}, 32'h0);
    bank_sel = 1; #1;
    chk("R5 now active", rd_a_data, 32'hF3);
    chk("R5 side sees bank0", alt_rdata, 32'hA1);
    idle();

    // R8 R9: side port blocked in user mode
    priv_mode = 0; alt_en = 1; alt_we = 1; alt_idx = 3; alt_wdata = 32'h99; #1;
    chk("R8 side read zero", alt_rdata, 32'h0);
    tick();
    idle(); #1;
    chk("R9 fault after side", {31'h0, priv_fault}, 32'h1);
    tick();
    chk("R9 fault one cycle", {31'h0, priv_fault}, 32'h0);
    priv_mode = 1; bank_sel = 0; alt_en = 1; alt_idx = 3; rd_a_idx = 3; #1;
    chk("R8 hidden unchanged", alt_rdata, 32'hF3);
    chk("R8 active unchanged", rd_a_data, 32'hA1);
    idle();

    // R6: same-cycle read of written register sees old value
    rd_a_idx = 5; wr_en = 1; wr_idx = 5; wr_data = 32'h55; #1;
    chk("R6 no bypass", rd_a_data, 32'h0);
    tick();
    wr_en = 0; #1;
    chk("R6 written at edge", rd_a_data, 32'h55);

    // R7 R8 R9: control registers
    ctl_write(4'd8, 32'h80);
    ctl_write(4'd2, 32'h22);
    ctl_write(4'd12, 32'hCC);
    ctl_sel = 4'd12; #1;
    chk("R7 invalid code zero", ctl_rdata, 32'h0);
    priv_mode = 0; ctl_en = 1; ctl_we = 1; ctl_sel = 4'd8; ctl_wdata = 32'hFF; #1;
    chk("R8 priv ctrl read zero", ctl_rdata, 32'h0);
    tick();
    idle(); #1;
    chk("R9 fault after ctrl", {31'h0, priv_fault}, 32'h1);
    ctl_sel = 4'd2; #1;
    chk("R7 open code in user", ctl_rdata, 32'h22);
    ctl_write(4'd2, 32'h33);
    ctl_sel = 4'd2; #1;
    chk("R7 user write open code", ctl_rdata, 32'h33);
    chk("R9 no fault open code", {31'h0, priv_fault}, 32'h0);
    priv_mode = 1; ctl_sel = 4'd8; #1;
    chk("R8 blocked write dropped", ctl_rdata, 32'h80);

    // R1: reset clears every store
    wr_en = 1; wr_idx = 12; wr_data = 32'h12; tick(); idle();
    rst = 1; tick(); rst = 0; #1;
    priv_mode = 1; bank_sel = 1; rd_a_idx = 3; rd_b_idx = 12; alt_idx = 3; alt_en = 1; #1;
    chk("R1 bank1 cleared", rd_a_data, 32'h0);
    chk("R1 shared cleared", rd_b_data, 32'h0);
    chk("R1 bank0 cleared", alt_rdata, 32'h0);
    ctl_sel = 4'd8; #1;
    chk("R1 ctrl priv cleared", ctl_rdata, 32'h0);
    ctl_sel = 4'd2; #1;
    chk("R1 ctrl open cleared", ctl_rdata, 32'h0);
    idle();

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule